// File: doc/BRIEF.md
# Block Buffer Ready Tracker

This block follows how full a byte buffer is while whole data blocks pass through it, one side writing bytes in from the card data lines and the local host reading them out, without DMA. Only the counting and the status flags live here. The storage array, the DMA paths and the command engine belong to other blocks.

The block length comes from an 11-bit field. Readiness is judged in whole blocks of that length, not byte by byte. A read-ready flag tells the host that a complete block is waiting. It stays up while the host drains that block and drops once the last byte of the block is taken. A write-ready flag tells the card side that a full block of space is free. The rising edge of read-ready gives a one-clock interrupt pulse. A read-transfer-active flag follows the end bit of a read command, the final block, and the stop-at-block-gap and continue controls. A length of zero means no transfer is set up.

Top module: `block_buf_tracker`

## Requirements
- R1: After synchronous reset the buffer is empty, and rd_ready, rd_ready_irq and rd_active are low. wr_ready is high whenever blk_len is nonzero.
- R2: The block length is the unsigned byte count on the 11-bit blk_len input (1 to 2047). Each accepted card_wr or host_rd pulse moves exactly one byte.
- R3: rd_ready goes high in the cycle after the write that completes blk_len bytes beyond all blocks the host has already finished reading.
- R4: rd_ready stays high while the host reads the current block. It goes low in the cycle after the block's last byte is read, unless another full block is already buffered.
- R5: rd_ready_irq is high for exactly one cycle, in the first cycle that rd_ready is high, and never while rd_ready stays high.
- R6: wr_ready is high exactly when the free space, BUF_BYTES minus the bytes held, is at least blk_len.
- R7: While blk_len is 0, rd_ready and wr_ready are low and card_wr and host_rd pulses are ignored.
- R8: A card_wr pulse while the buffer holds BUF_BYTES bytes is dropped. A host_rd pulse while rd_ready is low is dropped.
- R9: rd_active is high in the cycle after a rd_cmd_end pulse.
- R10: When the last byte of a block is read while final_blk is high, rd_active goes low in the next cycle.
- R11: When the last byte of a block is read while stop_gap is high (and final_blk is low), rd_active goes low and the block enters a gap hold. A cont_req pulse in gap hold sets rd_active again. A cont_req pulse outside gap hold is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_len | input | 11 | Block length in bytes, 0 means no transfer |
| card_wr | input | 1 | One byte written into the buffer from the card side |
| host_rd | input | 1 | One byte read from the buffer by the host |
| rd_cmd_end | input | 1 | Pulse at the end bit of a read command |
| final_blk | input | 1 | The block now being read is the last of the transfer |
| stop_gap | input | 1 | Stop-at-block-gap request level |
| cont_req | input | 1 | Continue request pulse after a gap stop |
| rd_ready | output | 1 | A complete block is readable |
| wr_ready | output | 1 | Room for a complete block exists |
| rd_ready_irq | output | 1 | One-cycle pulse when rd_ready rises |
| rd_active | output | 1 | Read transfer in progress |

## Verification
The bench targets the block boundary: the byte that completes a block and the byte that finishes reading it. A design that counted single bytes would raise rd_ready one byte early or drop it in the middle of a block. With two blocks buffered, rd_ready has to stay up across the boundary without a second interrupt, so a flag that toggled there would produce a double pulse. Writes into a full buffer, reads while nothing is ready, and traffic at length zero must leave the byte count unchanged; leaks show up later as wrong write-ready or read-ready levels. Continue requests outside a gap hold, and final versus stop at a block end, are checked so that a wrong state machine leaves rd_active at the wrong level.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    localparam int LEN_W = 11;

    typedef logic [LEN_W-1:0] blk_len_t;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_ACTIVE = 2'd1,
        XS_HOLD   = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic wr_acc;
        logic rd_acc;
        logic blk_done;
    } byte_evt_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bbt_byte_counter.sv
module bbt_byte_counter
    import bbt_pkg::*;
#(
    parameter int BUF_BYTES = 4096,
    parameter int OCC_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  blk_len_t         blk_len,
    input  logic             card_wr,
    input  logic             host_rd,
    input  logic             rd_ok,
    output logic [OCC_W-1:0] occ,
    output blk_len_t         rd_in_blk,
    output byte_evt_t        evt
);

    localparam logic [OCC_W-1:0] FULL = OCC_W'(BUF_BYTES);

    logic len_zero;
    logic last_byte;

    always_comb begin
        len_zero     = (blk_len == '0);
        evt.wr_acc   = card_wr && !len_zero && (occ != FULL);
        evt.rd_acc   = host_rd && !len_zero && rd_ok;
        last_byte    = (rd_in_blk == blk_len - blk_len_t'(1));
        evt.blk_done = evt.rd_acc && last_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            case ({evt.wr_acc, evt.rd_acc})
                2'b10:   occ <= occ + OCC_W'(1);
                2'b01:   occ <= occ - OCC_W'(1);
                default: occ <= occ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_in_blk <= '0;
        end else if (evt.blk_done) begin
            rd_in_blk <= '0;
        end else if (evt.rd_acc) begin
            rd_in_blk <= rd_in_blk + blk_len_t'(1);
        end
    end

    p_occ_bound_r8: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL);

    p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL && !evt.rd_acc) |=> occ == FULL);

    p_len0_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (blk_len == '0) |=> $stable(occ));

    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_acc && !evt.rd_acc) |=> occ == $past(occ) + OCC_W'(1));

endmodule

// File: rtl/bbt_flag_gen.sv
module bbt_flag_gen
    import bbt_pkg::*;
#(
    parameter int BUF_BYTES = 4096,
    parameter int OCC_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  blk_len_t         blk_len,
    input  logic [OCC_W-1:0] occ,
    input  blk_len_t         rd_in_blk,
    output logic             rd_ready,
    output logic             wr_ready,
    output logic             rd_irq
);

    localparam int AV_W = max_int(OCC_W, LEN_W) + 1;
    localparam logic [AV_W-1:0] CAP = AV_W'(BUF_BYTES);

    logic [AV_W-1:0] avail;
    logic [AV_W-1:0] space;
    logic [AV_W-1:0] need;
    logic            rd_ready_q;

    always_comb begin
        need     = AV_W'(blk_len);
        avail    = AV_W'(occ) + AV_W'(rd_in_blk);
        space    = CAP - AV_W'(occ);
        rd_ready = (need != '0) && (avail >= need);
        wr_ready = (need != '0) && (space >= need);
        rd_irq   = rd_ready && !rd_ready_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_ready_q <= 1'b0;
        else     rd_ready_q <= rd_ready;
    end

    p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
        rd_irq |=> !rd_irq);

    p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && $past(rd_ready)) |-> !rd_irq);

endmodule

// File: rtl/bbt_xfer_ctrl.sv
module bbt_xfer_ctrl
    import bbt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_evt_t evt,
    input  logic      rd_cmd_end,
    input  logic      final_blk,
    input  logic      stop_gap,
    input  logic      cont_req,
    output logic      rd_active
);

    xfer_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            XS_IDLE: begin
                if (rd_cmd_end) state_nx = XS_ACTIVE;
            end
            XS_ACTIVE: begin
                if (rd_cmd_end)                        state_nx = XS_ACTIVE;
                else if (evt.blk_done && final_blk)    state_nx = XS_IDLE;
                else if (evt.blk_done && stop_gap)     state_nx = XS_HOLD;
            end
            XS_HOLD: begin
                if (rd_cmd_end || cont_req) state_nx = XS_ACTIVE;
            end
            default: state_nx = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= XS_IDLE;
        else     state <= state_nx;
    end

    assign rd_active = (state == XS_ACTIVE);

    p_cmd_sets_r9: assert property (@(posedge clk) disable iff (rst)
        rd_cmd_end |=> rd_active);

    p_final_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_active && evt.blk_done && final_blk && !rd_cmd_end) |=> !rd_active);

    p_cont_resume_r11: assert property (@(posedge clk) disable iff (rst)
        (state == XS_HOLD && cont_req) |=> rd_active);

    p_idle_cont_r11: assert property (@(posedge clk) disable iff (rst)
        (state == XS_IDLE && cont_req && !rd_cmd_end) |=> !rd_active);

endmodule

// File: rtl/block_buf_tracker.sv
module block_buf_tracker
    import bbt_pkg::*;
#(
    parameter int BUF_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [10:0] blk_len,
    input  logic        card_wr,
    input  logic        host_rd,
    input  logic        rd_cmd_end,
    input  logic        final_blk,
    input  logic        stop_gap,
    input  logic        cont_req,
    output logic        rd_ready,
    output logic        wr_ready,
    output logic        rd_ready_irq,
    output logic        rd_active
);

    localparam int OCC_W = $clog2(BUF_BYTES + 1);

    logic [OCC_W-1:0] occ;
    blk_len_t         rd_in_blk;
    byte_evt_t        evt;

    bbt_byte_counter #(.BUF_BYTES(BUF_BYTES), .OCC_W(OCC_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .blk_len   (blk_len),
        .card_wr   (card_wr),
        .host_rd   (host_rd),
        .rd_ok     (rd_ready),
        .occ       (occ),
        .rd_in_blk (rd_in_blk),
        .evt       (evt)
    );

    bbt_flag_gen #(.BUF_BYTES(BUF_BYTES), .OCC_W(OCC_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .blk_len   (blk_len),
        .occ       (occ),
        .rd_in_blk (rd_in_blk),
        .rd_ready  (rd_ready),
        .wr_ready  (wr_ready),
        .rd_irq    (rd_ready_irq)
    );

    bbt_xfer_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .rd_cmd_end (rd_cmd_end),
        .final_blk  (final_blk),
        .stop_gap   (stop_gap),
        .cont_req   (cont_req),
        .rd_active  (rd_active)
    );

    p_rd_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !rd_ready) |=> $stable(occ));

    p_blk_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && evt.rd_acc && !evt.blk_done) |=> rd_ready);

endmodule

// File: tb/block_buf_tracker_tb.sv
`timescale 1ns/1ps
module block_buf_tracker_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] blk_len;
    logic        card_wr, host_rd, rd_cmd_end, final_blk, stop_gap, cont_req;
    logic        rd_ready, wr_ready, rd_ready_irq, rd_active;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    block_buf_tracker #(.BUF_BYTES(64)) u_dut (
        .clk(clk), .rst(rst), .blk_len(blk_len), .card_wr(card_wr),
        .host_rd(host_rd), .rd_cmd_end(rd_cmd_end), .final_blk(final_blk),
        .stop_gap(stop_gap), .cont_req(cont_req), .rd_ready(rd_ready),
        .wr_ready(wr_ready), .rd_ready_irq(rd_ready_irq), .rd_active(rd_active)
    );

    always @(negedge clk) if (!rst && rd_ready_irq) irq_seen++;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            card_wr = 1'b1;
            @(negedge clk);
        end
        card_wr = 1'b0;
    endtask

    task automatic read_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            host_rd = 1'b1;
            @(negedge clk);
        end
        host_rd = 1'b0;
    endtask

    task automatic pulse_cmd_end();
        rd_cmd_end = 1'b1; @(negedge clk); rd_cmd_end = 1'b0;
    endtask

    task automatic pulse_cont();
        cont_req = 1'b1; @(negedge clk); cont_req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; blk_len = 11'd16;
        card_wr = 0; host_rd = 0; rd_cmd_end = 0; final_blk = 0; stop_gap = 0; cont_req = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_ready", rd_ready, 1'b0);
        chk("R1 irq", rd_ready_irq, 1'b0);
        chk("R1 rd_active", rd_active, 1'b0);
        chk("R1 wr_ready", wr_ready, 1'b1);
    endtask

    task automatic t_one_block();
        irq_seen = 0;
        write_bytes(15);
        chk("R3 short of block", rd_ready, 1'b0);
        card_wr = 1'b1; @(negedge clk); card_wr = 1'b0;
        chk("R3 block complete", rd_ready, 1'b1);
        chk("R5 irq on rise", rd_ready_irq, 1'b1);
        @(negedge clk);
        chk("R5 irq one cycle", rd_ready_irq, 1'b0);
        read_bytes(15);
        chk("R4 held mid block", rd_ready, 1'b1);
        read_bytes(1);
        chk("R4 cleared after block", rd_ready, 1'b0);
        chk_int("R5 irq count", irq_seen, 1);
    endtask

    task automatic t_two_blocks();
        irq_seen = 0;
        write_bytes(32);
        read_bytes(16);
        chk("R4 second block keeps ready", rd_ready, 1'b1);
        read_bytes(16);
        chk("R4 drained", rd_ready, 1'b0);
        chk_int("R5 single irq for two blocks", irq_seen, 1);
    endtask

    task automatic t_space_and_full();
        blk_len = 11'd40;
        @(negedge clk);
        chk("R6 empty room", wr_ready, 1'b1);
        write_bytes(24);
        chk("R6 room exactly 40", wr_ready, 1'b1);
        write_bytes(1);
        chk("R6 room 39", wr_ready, 1'b0);
        write_bytes(39);
        write_bytes(5);
        chk("R3 full buffer ready", rd_ready, 1'b1);
        read_bytes(40);
        chk("R4 one block consumed", rd_ready, 1'b0);
        chk("R8 full writes dropped", wr_ready, 1'b1);
        read_bytes(3);
        write_bytes(16);
        chk("R8 reads dropped while not ready", rd_ready, 1'b1);
        read_bytes(40);
        chk("R2 buffer empty again", rd_ready, 1'b0);
        chk("R6 empty room again", wr_ready, 1'b1);
    endtask

    task automatic t_zero_len();
        blk_len = 11'd0;
        @(negedge clk);
        chk("R7 rd_ready low", rd_ready, 1'b0);
        chk("R7 wr_ready low", wr_ready, 1'b0);
        write_bytes(5);
        chk("R7 no ready at zero", rd_ready, 1'b0);
        blk_len = 11'd5;
        @(negedge clk);
        chk("R7 writes ignored", rd_ready, 1'b0);
    endtask

    task automatic t_final();
        pulse_cmd_end();
        chk("R9 active after end bit", rd_active, 1'b1);
        final_blk = 1'b1;
        write_bytes(5);
        read_bytes(4);
        chk("R10 active mid block", rd_active, 1'b1);
        read_bytes(1);
        chk("R10 cleared at final", rd_active, 1'b0);
        final_blk = 1'b0;
    endtask

    task automatic t_gap();
        pulse_cont();
        chk("R11 cont ignored idle", rd_active, 1'b0);
        pulse_cmd_end();
        chk("R9 active again", rd_active, 1'b1);
        stop_gap = 1'b1;
        write_bytes(5);
        read_bytes(5);
        chk("R11 stopped at gap", rd_active, 1'b0);
        stop_gap = 1'b0;
        @(negedge clk);
        chk("R11 stays stopped", rd_active, 1'b0);
        pulse_cont();
        chk("R11 continue resumes", rd_active, 1'b1);
        final_blk = 1'b1;
        write_bytes(5);
        read_bytes(5);
        chk("R10 final after continue", rd_active, 1'b0);
        final_blk = 1'b0;
    endtask

    initial begin
        t_reset();
        t_one_block();
        t_two_blocks();
        t_space_and_full();
        t_zero_len();
        t_final();
        t_gap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule